// File: doc/BRIEF.md
# Dual-Field Montgomery Multiplier

This block computes the Montgomery product of two operands, either as integers modulo an odd prime-field modulus or as binary polynomials modulo an odd polynomial. One datapath and one clock serve both fields. A single mode input picks integer (carry) or polynomial (carry-less, XOR) accumulation. The caller supplies both operands, the modulus and the per-modulus Montgomery constant as 256-bit and 64-bit vectors, pulses start, and waits for the done pulse. The product then sits in a result register until the next operation completes.

The operand length is a run-time input in 64-bit words (1 to 4), so shorter keys finish sooner. Prime-field mode scans the multiplier operand in 16-bit digits. Four parallel lanes each cover one 64-bit slice of the multiplicand and the modulus. Binary-field mode scans 64-bit digits with the same lanes, which keeps the carry path short in both modes. The Montgomery factor is R = 2^(64·W) in prime mode or x^(64·W) in binary mode, where W is the word count. Operand bits above 64·W must be zero, and the modulus must be odd (constant term 1).

Top module: `dualfield_mont_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and result_o is all zeros.
- R2: A start_i pulse sampled while idle raises busy_o on the next cycle. done_o is a one-cycle pulse in the same cycle that busy_o falls. It appears D+2 clock edges after the edge preceding the start cycle's sampling edge is counted as zero, where D = 4·W in prime mode and D = W in binary mode.
- R3: With field_i = 0 (prime field), an odd M, B < M and A < 2^(64·W), the result is A·B·2^(-64·W) mod M and is strictly less than M. Only bits 15:0 of minv_i are used, and they must hold −M⁻¹ mod 2^16.
- R4: With field_i = 1 (binary field), bit i of each vector is the coefficient of x^i. With M odd, deg B < deg M, deg M = 64·W−1 or lower, and minv_i = M⁻¹ mod x^64, the result is A·B·x^(-64·W) mod M with degree below deg M.
- R5: A start_i pulse while busy_o is high is ignored. The running operation's result, latency and operands are unaffected, and no extra done_o pulse follows.
- R6: result_o holds its value in every cycle except the one in which done_o is high, including the whole time a later operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| field_i | input | 1 | 0 = prime field, 1 = binary field |
| words_i | input | 3 | Operand length in 64-bit words, 1 to 4 |
| a_i | input | 256 | Multiplier operand A |
| b_i | input | 256 | Multiplicand operand B |
| m_i | input | 256 | Modulus M |
| minv_i | input | 64 | Montgomery constant for the selected field |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 256 | Montgomery product, held between completions |

## Verification
The bench uses operand pairs near the modulus, so the last running sum lands between M and 2M. A design that skips or misplaces the conditional subtraction returns a value at or above M. Binary-mode vectors have dense bit patterns, so a carry leaking into the polynomial path corrupts high coefficients. Every word count is covered in both modes, with a latency check per operation. A wrong digit count or shift amount therefore gives the wrong power of R, or a done pulse in the wrong cycle. In prime mode, minv_i carries random upper bits and a second start arrives during a run with different operands and mode. Reading too many constant bits, or reloading while busy, corrupts the expected product or adds a stray done pulse.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic {
      FLD_PRIME  = 1'b0,
      FLD_BINARY = 1'b1
   } field_e;
endpackage

// File: rtl/mm_umul.sv
// Unified shift-and-accumulate multiplier: integer (add) or carry-less (XOR)
// accumulation of the partial products, truncated to PW bits.
module mm_umul #(
   parameter int W  = 64,
   parameter int PW = 2 * W
) (
   input  logic          bin_i,
   input  logic [W-1:0]  x_i,
   input  logic [W-1:0]  y_i,
   output logic [PW-1:0] p_o
);
   initial begin
      if (PW < W) $error("mm_umul: product width below operand width");
   end

   always_comb begin
      logic [PW-1:0] acc;
      logic [PW-1:0] pp;
      acc = '0;
      for (int j = 0; j < W; j++) begin
         pp = PW'(y_i) << j;
         if (x_i[j]) begin
            if (bin_i) acc = acc ^ pp;
            else       acc = acc + pp;
         end
      end
      p_o = acc;
   end
endmodule

// File: rtl/mm_fixup.sv
// Final correction: one conditional subtraction in the prime field,
// pass-through in the binary field.
module mm_fixup #(
   parameter int N  = 256,
   parameter int TW = N + 1
) (
   input  logic          bin_i,
   input  logic [TW-1:0] t_i,
   input  logic [N-1:0]  m_i,
   output logic [N-1:0]  r_o
);
   logic [TW-1:0] m_ext;
   logic [TW-1:0] diff;
   logic          ge;

   assign m_ext = TW'(m_i);
   assign diff  = t_i - m_ext;
   assign ge    = (t_i >= m_ext);
   assign r_o   = (!bin_i && ge) ? N'(diff) : N'(t_i);
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
   parameter int WC_W  = 3,
   parameter int CNT_W = 5,
   parameter int DPW   = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic            bin_i,
   input  logic [WC_W-1:0] words_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            load_o,
   output logic            step_o,
   output logic            fix_o
);
   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_e;

   st_e              st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] total_d;
   logic             done_q;

   assign load_o  = (st_q == S_IDLE) && start_i;
   assign step_o  = (st_q == S_RUN);
   assign fix_o   = (st_q == S_FIX);
   assign busy_o  = (st_q != S_IDLE);
   assign done_o  = done_q;
   assign total_d = bin_i ? CNT_W'(words_i) : CNT_W'(words_i) * CNT_W'(DPW);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         total_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= fix_o;
         unique case (st_q)
            S_IDLE: if (start_i) begin
               st_q    <= S_RUN;
               cnt_q   <= '0;
               total_q <= total_d;
            end
            S_RUN: begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == total_q - CNT_W'(1)) st_q <= S_FIX;
            end
            S_FIX:   st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R2
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o))); // R2
   AST_STEP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && cnt_q != total_q - CNT_W'(1)) |=> (step_o && cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_o) |=> $stable(total_q)); // R5
endmodule

// File: rtl/dualfield_mont_mul.sv
module dualfield_mont_mul
   import mm_pkg::*;
#(
   parameter int N     = 256,
   parameter int WORD  = 64,
   parameter int PDIG  = 16,
   parameter int LANES = N / WORD
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       start_i,
   input  logic                       field_i,
   input  logic [$clog2(LANES+1)-1:0] words_i,
   input  logic [N-1:0]               a_i,
   input  logic [N-1:0]               b_i,
   input  logic [N-1:0]               m_i,
   input  logic [WORD-1:0]            minv_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [N-1:0]               result_o
);
   localparam int TW    = N + 1;
   localparam int SUMW  = TW + WORD;
   localparam int WC_W  = $clog2(LANES + 1);
   localparam int DPW   = WORD / PDIG;
   localparam int CNT_W = $clog2(LANES * DPW + 1);

   initial begin
      if (N != LANES * WORD) $error("dualfield_mont_mul: N must equal LANES*WORD");
      if (WORD % PDIG != 0)  $error("dualfield_mont_mul: PDIG must divide WORD");
      if (PDIG > WORD)       $error("dualfield_mont_mul: PDIG wider than WORD");
   end

   logic            load, step, fix;
   logic [N-1:0]    a_sh, b_q, m_q, res_q, res_d;
   logic [WORD-1:0] minv_q;
   field_e          fld_q;
   logic            bin_q;
   logic [TW-1:0]   t_q, t_next;

   assign bin_q = (fld_q == FLD_BINARY);

   mm_ctrl #(.WC_W(WC_W), .CNT_W(CNT_W), .DPW(DPW)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .bin_i   (field_i),
      .words_i (words_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .load_o  (load),
      .step_o  (step),
      .fix_o   (fix)
   );

   // current digit of A: 16 bits (prime) or 64 bits (binary)
   logic [WORD-1:0] d_x;
   assign d_x = bin_q ? a_sh[WORD-1:0] : WORD'(a_sh[PDIG-1:0]);

   // quotient digit from the low digit of T + a_i*B
   logic [2*WORD-1:0] ab_p [LANES];
   logic [2*WORD-1:0] qm_p [LANES];
   logic [PDIG-1:0]   u_p;
   logic [WORD-1:0]   u_b, u_x, mi_x, q_full, q_x;

   assign u_p  = t_q[PDIG-1:0] + ab_p[0][PDIG-1:0];
   assign u_b  = t_q[WORD-1:0] ^ ab_p[0][WORD-1:0];
   assign u_x  = bin_q ? u_b : WORD'(u_p);
   assign mi_x = bin_q ? minv_q : WORD'(minv_q[PDIG-1:0]);

   mm_umul #(.W(WORD), .PW(WORD)) u_qmul (
      .bin_i (bin_q),
      .x_i   (u_x),
      .y_i   (mi_x),
      .p_o   (q_full)
   );

   assign q_x = bin_q ? q_full : WORD'(q_full[PDIG-1:0]);

   // per-lane products over 64-bit slices of B and M
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      mm_umul #(.W(WORD), .PW(2*WORD)) u_ab (
         .bin_i (bin_q),
         .x_i   (d_x),
         .y_i   (b_q[k*WORD +: WORD]),
         .p_o   (ab_p[k])
      );
      mm_umul #(.W(WORD), .PW(2*WORD)) u_qm (
         .bin_i (bin_q),
         .x_i   (q_x),
         .y_i   (m_q[k*WORD +: WORD]),
         .p_o   (qm_p[k])
      );
   end

   // lane merge: T + a_i*B + q*M, added or XORed per field
   logic [SUMW-1:0] acc;
   always_comb begin
      logic [SUMW-1:0] term;
      acc = SUMW'(t_q);
      for (int k = 0; k < LANES; k++) begin
         term = SUMW'(ab_p[k]) << (k * WORD);
         acc  = bin_q ? (acc ^ term) : (acc + term);
         term = SUMW'(qm_p[k]) << (k * WORD);
         acc  = bin_q ? (acc ^ term) : (acc + term);
      end
   end

   assign t_next = bin_q ? TW'(acc >> WORD) : TW'(acc >> PDIG);

   mm_fixup #(.N(N), .TW(TW)) u_fix (
      .bin_i (bin_q),
      .t_i   (t_q),
      .m_i   (m_q),
      .r_o   (res_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_sh   <= '0;
         b_q    <= '0;
         m_q    <= '0;
         minv_q <= '0;
         fld_q  <= FLD_PRIME;
         t_q    <= '0;
         res_q  <= '0;
      end else begin
         if (load) begin
            a_sh   <= a_i;
            b_q    <= b_i;
            m_q    <= m_i;
            minv_q <= minv_i;
            fld_q  <= field_e'(field_i);
            t_q    <= '0;
         end else if (step) begin
            a_sh <= bin_q ? (a_sh >> WORD) : (a_sh >> PDIG);
            t_q  <= t_next;
         end
         if (fix) res_q <= res_d;
      end
   end

   assign result_o = res_q;

   AST_DIGIT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step |-> (bin_q ? (acc[WORD-1:0] == '0) : (acc[PDIG-1:0] == '0))); // R3
   AST_PRIME_REDUCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !bin_q) |-> (result_o < m_q)); // R3
   AST_BIN_DEGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && bin_q) |-> (result_o < m_q)); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o)); // R6
endmodule

// File: tb/test_dualfield_mont_mul.sv
module test_dualfield_mont_mul;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         field = 1'b0;
   logic [2:0]   words = 3'd1;
   logic [255:0] a = '0, b = '0, m = '0;
   logic [63:0]  minv = '0;
   logic         busy, done;
   logic [255:0] result;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic [255:0] prev_exp = '0;

   typedef struct {
      logic [255:0] exp;
      int           c0;
      int           lat;
      bit           bin;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dualfield_mont_mul i_dualfield_mont_mul (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .field_i(field),
      .words_i(words), .a_i(a), .b_i(b), .m_i(m), .minv_i(minv),
      .busy_o(busy), .done_o(done), .result_o(result)
   );

   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [255:0] wmask(input int wc);
      return (wc >= 4) ? {256{1'b1}} : ((256'(1) << (64 * wc)) - 256'(1));
   endfunction

   function automatic logic [255:0] ref_prime(input logic [255:0] x, y, md, input int wc);
      logic [519:0] p;
      p = 520'(x) * 520'(y);
      for (int i = 0; i < 64 * wc; i++) begin
         if (p[0]) p = p + 520'(md);
         p = p >> 1;
      end
      p = p % 520'(md);
      return p[255:0];
   endfunction

   function automatic logic [255:0] ref_bin(input logic [255:0] x, y, md, input int wc);
      logic [511:0] p;
      int dm;
      p = '0;
      dm = 0;
      for (int j = 0; j < 256; j++) if (y[j]) p = p ^ (512'(x) << j);
      for (int i = 0; i < 64 * wc; i++) begin
         if (p[0]) p = p ^ 512'(md);
         p = p >> 1;
      end
      for (int k = 255; k >= 0; k--) if (md[k]) begin dm = k; break; end
      for (int k = 511; k >= dm; k--) if (p[k]) p = p ^ (512'(md) << (k - dm));
      return p[255:0];
   endfunction

   function automatic logic [63:0] clmul_lo(input logic [63:0] x, y);
      logic [63:0] r;
      r = '0;
      for (int j = 0; j < 64; j++) if (y[j]) r = r ^ (x << j);
      return r;
   endfunction

   function automatic logic [15:0] prime_minv(input logic [15:0] md);
      logic [15:0] x;
      x = md;
      for (int i = 0; i < 4; i++) x = x * (16'd2 - md * x);
      return -x;
   endfunction

   function automatic logic [63:0] bin_minv(input logic [63:0] md);
      logic [63:0] x;
      x = 64'd1;
      for (int i = 0; i < 6; i++) x = clmul_lo(clmul_lo(x, x), md);
      return x;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R5 unexpected done pulse", 256'(1), 256'(0));
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(result == it.exp, it.bin ? "R4 binary product" : "R3 prime product", result, it.exp);
            chk(!busy, "R2 busy low with done", 256'(busy), 256'(0));
            chk((cyc - it.c0) == it.lat, "R2 latency", 256'(cyc - it.c0), 256'(it.lat));
         end
      end
   end

   task automatic run_op(input bit bin, input int wc, input logic [255:0] x, y, md,
                         input logic [63:0] mi, input bit ign);
      item_t it;
      it.exp = bin ? ref_bin(x, y, md, wc) : ref_prime(x, y, md, wc);
      it.bin = bin;
      it.lat = (bin ? wc : 4 * wc) + 2;
      @(negedge clk);
      field = bin; words = 3'(wc); a = x; b = y; m = md; minv = mi; start = 1'b1;
      it.c0 = cyc;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R2 busy after start", 256'(busy), 256'(1));
      chk(result == prev_exp, "R6 result held while busy", result, prev_exp);
      if (ign) begin
         a = ~x; b = x; field = ~bin; words = 3'd4; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy, "R5 still busy after ignored start", 256'(busy), 256'(1));
      end
      while (sb.size() != 0) @(negedge clk);
      prev_exp = it.exp;
      @(negedge clk);
      @(negedge clk);
      chk(result == prev_exp, "R6 result held after done", result, prev_exp);
      chk(!done && !busy, "R5 no second completion", 256'({done, busy}), 256'(0));
   endtask

   task automatic prime_case(input int wc, input bit edge_ops, input bit ign);
      logic [255:0] md, x, y, msk;
      logic [63:0]  mi;
      msk = wmask(wc);
      md = (rnd256() & msk) | 256'(1) | (256'(1) << (64 * wc - 1));
      if (edge_ops) begin
         x = md - 256'(1);
         y = md - 256'(1);
      end else begin
         x = rnd256() & msk;
         y = (rnd256() & msk) % md;
      end
      mi = {$urandom, $urandom};
      mi[15:0] = prime_minv(md[15:0]);
      run_op(1'b0, wc, x, y, md, mi, ign);
   endtask

   task automatic bin_case(input int wc, input bit dense, input bit ign);
      logic [255:0] md, x, y, msk;
      msk = wmask(wc);
      md = (rnd256() & msk) | 256'(1) | (256'(1) << (64 * wc - 1));
      x = dense ? msk : (rnd256() & msk);
      y = dense ? (msk >> 1) : (rnd256() & (msk >> 1));
      run_op(1'b1, wc, x, y, md, bin_minv(md[63:0]), ign);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!busy, "R1 busy in reset", 256'(busy), 256'(0));
      chk(!done, "R1 done in reset", 256'(done), 256'(0));
      chk(result == '0, "R1 result in reset", result, 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && result == '0, "R1 idle after reset", result, 256'(0));

      // R3: prime field, every word count, random operands
      for (int wc = 1; wc <= 4; wc++)
         for (int r = 0; r < 3; r++) prime_case(wc, 1'b0, 1'b0);
      // R3: operands at M-1 drive the final sum into [M, 2M)
      for (int wc = 1; wc <= 4; wc++) prime_case(wc, 1'b1, 1'b0);
      // R3: all-ones modulus, zero multiplier
      run_op(1'b0, 4, {256{1'b1}} - 256'(1), {256{1'b1}} - 256'(2), {256{1'b1}},
             {48'hA5A5_5A5A_C3C3, prime_minv(16'hFFFF)}, 1'b0);
      run_op(1'b0, 2, '0, 256'h1234, (256'(1) << 127) | 256'h3B,
             {48'h0, prime_minv(16'h003B)}, 1'b0);

      // R4: binary field, every word count, random and dense operands
      for (int wc = 1; wc <= 4; wc++)
         for (int r = 0; r < 3; r++) bin_case(wc, 1'b0, 1'b0);
      for (int wc = 1; wc <= 4; wc++) bin_case(wc, 1'b1, 1'b0);
      run_op(1'b1, 1, '0, 256'hFFFF, 256'h8000_0000_0000_001B, bin_minv(64'h8000_0000_0000_001B), 1'b0);

      // R5: start requests during a run, both fields, shortest and longest
      prime_case(1, 1'b0, 1'b1);
      prime_case(4, 1'b1, 1'b1);
      bin_case(1, 1'b0, 1'b1);
      bin_case(4, 1'b1, 1'b1);

      repeat (5) @(negedge clk);
      chk(sb.size() == 0, "R5 scoreboard drained", 256'(sb.size()), 256'(0));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule